// File: doc/BRIEF.md
# Multi-Channel Data-Ready Generator

This block turns per-channel "new conversion result" events from three converter channels into a single data-ready pin. Every channel whose enable input is set keeps a pending flag that is raised by its new-data event and dropped by the read-out clear, which the surrounding logic pulses when the conversion results are shifted out. A 2-bit source select chooses whether the pin follows the last enabled channel to finish, any enabled channel, or the first enabled channel to finish.

Readiness is shown active low. In level format the pin stays low until the read-out clear. In pulse format each qualifying event produces a low pulse of fixed length. When nothing is ready, the pin is either driven high or released, with its output enable low, as set by an idle select input.

Top module: `rdy_pin_gen`

## Requirements
- R1: After reset no channel is pending, no pulse is running, and the pin is idle: level 1, with the output enable following the idle select.
- R2: Source select 00 (last-finishing): readiness is reached only when every enabled channel is pending. In pulse format one pulse is started when that condition first becomes true.
- R3: Source select 01 (any): in level format the pin is low while any enabled channel is pending. In pulse format every new-data event on an enabled channel starts a pulse, even when other channels are already pending.
- R4: Source selects 10 and 11 (first-finishing): the level is the same as for 01. In pulse format only the first enabled channel to become pending after a clear starts a pulse, and later arrivals start none.
- R5: Level format: the pin goes low in the cycle after the edge that makes the selected condition true. It stays low until the edge that samples the read-out clear high, and it is back high in the next cycle.
- R6: Pulse format: the pin is low for exactly PULSE_LEN (default 4) cycles, starting two edges after the new-data event is sampled. A new qualifying event during a pulse restarts the full length.
- R7: With the idle select at 0, an idle pin is driven high with the output enable at 1. With the idle select at 1, an idle pin has the output enable at 0 and the level at 1. An active pin is driven low with the output enable at 1.
- R8: A new-data event on a channel whose enable is 0 has no effect. Clearing a channel's enable drops its pending flag on the next edge.
- R9: With no channel enabled the pin stays idle under every source select.
- R10: A new-data event sampled on the same edge as the read-out clear leaves that channel pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chEnable | input | NUM_CH | Per-channel participation enable |
| srcSel | input | 2 | Source select: 00 last-finishing, 01 any, 10/11 first-finishing |
| pulseMode | input | 1 | 0 = held low level, 1 = fixed-length low pulse |
| idleHiZ | input | 1 | 0 = drive high when idle, 1 = release the pin when idle |
| newData | input | NUM_CH | One-cycle new-result event per channel |
| readClr | input | 1 | One-cycle read-out clear of all pending flags |
| pinLevel | output | 1 | Pin level (active low) |
| pinOe | output | 1 | Pin output enable |

## Verification
A level-format result is due in the cycle that follows the edge sampling the deciding event or clear. A pulse begins one edge later than that and lasts PULSE_LEN cycles. The driver applies inputs at the falling edge and queues, for that same cycle, the pin level and output enable expected after the next rising edge. The monitor pops one item 2 ns after each rising edge, so every expectation is compared in exactly the cycle the rules predict. Pulse lengths, restarted pulses and release timing are therefore checked cycle by cycle.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  // source select encodings
  typedef enum logic [1:0] {
    SRC_LAG      = 2'b00,
    SRC_ANY      = 2'b01,
    SRC_LEAD     = 2'b10,
    SRC_LEAD_ALT = 2'b11
  } srcSel_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic clrPend;
    logic firePulse;
  } rdyStrobe_t;
endpackage

// File: rtl/rdy_datapath.sv
module rdy_datapath
  import rdy_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] newData,
  input  rdyStrobe_t        strobe,
  output logic [NUM_CH-1:0] pending,
  output logic              pulseActive
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] pulseCnt;

  // per-channel pending flags; a new event beats the clear
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pending[i] <= 1'b0;
      else if (!chEnable[i])     pending[i] <= 1'b0;
      else if (newData[i])       pending[i] <= 1'b1;
      else if (strobe.clrPend)   pending[i] <= 1'b0;
    end
  end

  // fixed-length pulse timer, reloaded on each fire
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pulseCnt <= '0;
    else if (strobe.firePulse) pulseCnt <= CNT_W'(PULSE_LEN);
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - 1'b1;
  end

  assign pulseActive = (pulseCnt != '0);

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clrPend && newData == '0) |=> (pending == '0));

  assert_pulse_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseCnt != '0 && !strobe.firePulse) |=> (pulseCnt == $past(pulseCnt) - 1'b1));

  assert_disabled_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & ~$past(chEnable)) == '0));
endmodule

// File: rtl/rdy_control.sv
module rdy_control
  import rdy_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [1:0]        srcSel,
  input  logic              pulseMode,
  input  logic [NUM_CH-1:0] newData,
  input  logic              readClr,
  input  logic [NUM_CH-1:0] pending,
  output rdyStrobe_t        strobe,
  output logic              readyNow
);
  logic [NUM_CH-1:0] livePend;
  logic anyEn, allPend, anyPend;
  logic readyPrev, evtSeen, fireRaw;

  assign livePend = pending & chEnable;
  assign anyEn    = |chEnable;
  assign allPend  = anyEn && (livePend == chEnable);
  assign anyPend  = |livePend;

  always_comb begin
    case (srcSel_e'(srcSel))
      SRC_LAG: readyNow = allPend;
      default: readyNow = anyPend;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyPrev <= 1'b0;
      evtSeen   <= 1'b0;
    end else begin
      readyPrev <= readyNow;
      evtSeen   <= |(newData & chEnable);
    end
  end

  always_comb begin
    case (srcSel_e'(srcSel))
      SRC_ANY: fireRaw = evtSeen;
      default: fireRaw = readyNow && !readyPrev;
    endcase
  end

  assign strobe.firePulse = pulseMode && fireRaw;
  assign strobe.clrPend   = readClr;

  assert_no_enable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chEnable == '0) |-> !readyNow);
endmodule

// File: rtl/rdy_pin_gen.sv
module rdy_pin_gen
  import rdy_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [1:0]        srcSel,
  input  logic              pulseMode,
  input  logic              idleHiZ,
  input  logic [NUM_CH-1:0] newData,
  input  logic              readClr,
  output logic              pinLevel,
  output logic              pinOe
);
  rdyStrobe_t        strobe;
  logic [NUM_CH-1:0] pending;
  logic              pulseActive, readyNow, active;

  rdy_control #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chEnable(chEnable), .srcSel(srcSel),
    .pulseMode(pulseMode), .newData(newData), .readClr(readClr),
    .pending(pending), .strobe(strobe), .readyNow(readyNow)
  );

  rdy_datapath #(.NUM_CH(NUM_CH), .PULSE_LEN(PULSE_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .chEnable(chEnable), .newData(newData),
    .strobe(strobe), .pending(pending), .pulseActive(pulseActive)
  );

  assign active   = pulseMode ? pulseActive : readyNow;
  assign pinLevel = !active;
  assign pinOe    = active || !idleHiZ;

  assert_released_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pinOe |-> pinLevel);

  assert_driven_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idleHiZ |-> pinOe);
endmodule

// File: tb/rdy_pin_gen_tb.sv
module rdy_pin_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] chEnable = 3'b111;
  logic [1:0] srcSel = 2'b00;
  logic       pulseMode = 1'b0;
  logic       idleHiZ = 1'b0;
  logic [2:0] newData = 3'b000;
  logic       readClr = 1'b0;
  logic       pinLevel, pinOe;

  typedef struct { bit lvl; bit oe; string tag; } exp_t;
  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rdy_pin_gen u_dut (
    .clk(clk), .rst_n(rst_n), .chEnable(chEnable), .srcSel(srcSel),
    .pulseMode(pulseMode), .idleHiZ(idleHiZ), .newData(newData),
    .readClr(readClr), .pinLevel(pinLevel), .pinOe(pinOe)
  );

  // monitor: one expected item per cycle, compared 2 ns after the edge
  always @(posedge clk) begin
    exp_t it;
    #2;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      nChecks++;
      if (pinLevel !== it.lvl || pinOe !== it.oe) begin
        nFails++;
        $display("FAIL %s: got lvl=%b oe=%b expected lvl=%b oe=%b",
                 it.tag, pinLevel, pinOe, it.lvl, it.oe);
      end
    end
  end

  // driver: one cycle of events plus the outputs expected after the edge
  task automatic cyc(input logic [2:0] nd, input logic clr,
                     input bit eLvl, input bit eOe, input string tag);
    exp_t it;
    @(negedge clk);
    newData = nd;
    readClr = clr;
    it.lvl = eLvl; it.oe = eOe; it.tag = tag;
    expQ.push_back(it);
  endtask

  // configuration change while idle
  task automatic cfg(input logic [2:0] en, input logic [1:0] sel,
                     input logic pm, input logic hz, input string tag);
    exp_t it;
    @(negedge clk);
    newData = '0; readClr = 1'b0;
    chEnable = en; srcSel = sel; pulseMode = pm; idleHiZ = hz;
    it.lvl = 1'b1; it.oe = !hz; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic finishSim();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got hung run expected completion");
      finishSim();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(3'b000, 0, 1, 1, "R1 reset idle");

    // R2/R5 last-finishing, level format
    cyc(3'b001, 0, 1, 1, "R2 one of three");
    cyc(3'b010, 0, 1, 1, "R2 two of three");
    cyc(3'b100, 0, 0, 1, "R2 all ready");
    cyc(3'b000, 0, 0, 1, "R5 held");
    cyc(3'b000, 0, 0, 1, "R5 held");
    cyc(3'b000, 1, 1, 1, "R5 released by clear");
    cyc(3'b000, 0, 1, 1, "R5 stays idle");

    // R3 any, level format; R10 event with clear
    cfg(3'b111, 2'b01, 0, 0, "R3 cfg");
    cyc(3'b010, 0, 0, 1, "R3 any channel");
    cyc(3'b000, 1, 1, 1, "R5 clear");
    cyc(3'b001, 1, 0, 1, "R10 event beats clear");
    cyc(3'b000, 1, 1, 1, "R10 later clear");

    // R8 disabled channel in last-finishing
    cfg(3'b101, 2'b00, 0, 0, "R8 cfg");
    cyc(3'b001, 0, 1, 1, "R2 subset partial");
    cyc(3'b010, 0, 1, 1, "R8 disabled event ignored");
    cyc(3'b100, 0, 0, 1, "R8 subset complete");
    cyc(3'b000, 1, 1, 1, "R5 clear");
    cfg(3'b101, 2'b01, 0, 0, "R8 cfg any");
    cyc(3'b010, 0, 1, 1, "R8 disabled alone");
    cyc(3'b001, 0, 0, 1, "R3 enabled event");
    cfg(3'b100, 2'b01, 0, 0, "R8 disable drops pending");

    // R9 nothing enabled
    cfg(3'b000, 2'b01, 0, 0, "R9 cfg");
    cyc(3'b111, 0, 1, 1, "R9 any none enabled");
    cfg(3'b000, 2'b00, 0, 0, "R9 cfg lag");
    cyc(3'b111, 0, 1, 1, "R9 lag none enabled");
    cfg(3'b000, 2'b10, 1, 0, "R9 cfg lead pulse");
    cyc(3'b111, 0, 1, 1, "R9 lead none enabled");
    cyc(3'b000, 0, 1, 1, "R9 no pulse");

    // R7 released idle
    cfg(3'b111, 2'b01, 0, 1, "R7 cfg hiz");
    cyc(3'b000, 0, 1, 0, "R7 released");
    cyc(3'b100, 0, 0, 1, "R7 active driven");
    cyc(3'b000, 1, 1, 0, "R7 released again");
    cfg(3'b111, 2'b01, 0, 0, "R7 driven idle");

    // R6/R3 pulse format, any
    cfg(3'b111, 2'b01, 1, 0, "R6 cfg");
    cyc(3'b001, 0, 1, 1, "R6 event edge");
    repeat (4) cyc(3'b000, 0, 0, 1, "R6 pulse low");
    cyc(3'b000, 0, 1, 1, "R6 pulse ends");
    cyc(3'b010, 0, 1, 1, "R3 second event");
    repeat (4) cyc(3'b000, 0, 0, 1, "R3 second pulse");
    cyc(3'b000, 0, 1, 1, "R3 pulse ends");
    cyc(3'b000, 1, 1, 1, "R6 clear");

    // R6 restart during pulse
    cyc(3'b001, 0, 1, 1, "R6 restart first");
    cyc(3'b000, 0, 0, 1, "R6 restart low");
    cyc(3'b010, 0, 0, 1, "R6 restart low");
    repeat (4) cyc(3'b000, 0, 0, 1, "R6 restarted length");
    cyc(3'b000, 0, 1, 1, "R6 restart ends");
    cyc(3'b000, 1, 1, 1, "R6 clear");

    // R4 first-finishing, pulse
    cfg(3'b111, 2'b10, 1, 0, "R4 cfg");
    cyc(3'b001, 0, 1, 1, "R4 first");
    repeat (4) cyc(3'b000, 0, 0, 1, "R4 pulse");
    cyc(3'b010, 0, 1, 1, "R4 later arrival");
    cyc(3'b000, 0, 1, 1, "R4 no second pulse");
    cyc(3'b000, 0, 1, 1, "R4 no second pulse");
    cyc(3'b000, 1, 1, 1, "R4 clear");
    cfg(3'b111, 2'b11, 1, 0, "R4 cfg alt");
    cyc(3'b100, 0, 1, 1, "R4 alt first");
    repeat (4) cyc(3'b000, 0, 0, 1, "R4 alt pulse");
    cyc(3'b000, 0, 1, 1, "R4 alt ends");
    cyc(3'b000, 1, 1, 1, "R4 clear");

    // R2 last-finishing, pulse
    cfg(3'b111, 2'b00, 1, 0, "R2 cfg pulse");
    cyc(3'b011, 0, 1, 1, "R2 partial");
    cyc(3'b100, 0, 1, 1, "R2 complete edge");
    repeat (4) cyc(3'b000, 0, 0, 1, "R2 pulse");
    cyc(3'b000, 0, 1, 1, "R2 pulse ends");
    cyc(3'b000, 1, 1, 1, "R2 clear");
    cyc(3'b000, 0, 1, 1, "R2 idle");

    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk); #3;
    done = 1'b1;
    finishSim();
  end
endmodule